// File: doc/BRIEF.md
# Receive Frame Packet Memory Writer

This block takes the byte stream that the receive side of an Ethernet MAC delivers, one byte per accepted cycle, and stores it in a 16-bit wide packet RAM. The layout in memory matches the layout that transmit packets use. A frame buffer begins with a status word, followed by a byte count word. The frame bytes come next, packed two to a word, and the buffer ends with a trailer word whose high byte is the control byte. Bytes are packed as they arrive, so the RAM sees one data write for every two received bytes.

The final status and length of a frame are only known once its last byte is in. For that reason the block first writes the trailer, and then writes the status word and the byte count back into the two header slots at the start of the buffer. After these writes it reports completion with a single-cycle pulse. The word address of the buffer is supplied by the surrounding logic together with the first byte of each frame. The classification flags are supplied together with the last byte.

Top module: `rx_pkt_writer`

## Requirements
- R1: While reset is active and on the first cycle after it, `in_ready` is 1, `done` is 0 and `mem_we` is 0.
- R2: Frame byte number i (counting from 0) is stored unchanged in word `base + 2 + i/2`. An even i goes to bits 7:0 and an odd i goes to bits 15:8.
- R3: The status word is written to word `base`. Its fields are: bit 15 alignment error, bit 14 broadcast, bit 13 CRC error, bit 12 odd length, bit 11 too long, bit 10 too short, bits 9:7 zero, bits 6:1 the multicast hash, and bit 0 multicast.
- R4: Status bit 12 is 1 exactly when the number of stored bytes is odd.
- R5: The byte count word is written to word `base + 1`. It equals the stored length plus 6 when that length is even, and plus 5 when it is odd, so the count is always even.
- R6: The trailer word is written to word `base + 2 + n/2`, where n is the stored length. For an odd n it holds 0x20 (the ODD bit, bit 5 of the control byte) in bits 15:8 and the last frame byte in bits 7:0. For an even n it is 0x0000.
- R7: The cycle after the last byte is accepted, `in_ready` drops. The trailer, status and count writes then follow on three consecutive cycles. `done` is high for one cycle, one cycle after the count write, and `in_ready` returns high in that same cycle.
- R8: A frame can store at most 1531 bytes. Any later bytes are accepted but dropped, the too-long bit is set, and the count becomes 1536. Nothing is written beyond the trailer word.
- R9: `base_addr` is sampled only with the first byte of a frame. Changing it later in the frame does not move any of that frame's writes.
- R10: The error and classification inputs are sampled only with the byte that carries `in_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_addr | input | AW | Word address of the frame buffer, taken with the first byte |
| in_valid | input | 1 | A received byte is present |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Marks the final byte of the frame |
| in_align | input | 1 | Alignment error flag, taken with the last byte |
| in_bcast | input | 1 | Broadcast flag, taken with the last byte |
| in_badcrc | input | 1 | CRC error flag, taken with the last byte |
| in_short | input | 1 | Frame too short flag, taken with the last byte |
| in_mcast | input | 1 | Multicast flag, taken with the last byte |
| in_hash | input | 6 | Multicast hash value, taken with the last byte |
| in_ready | output | 1 | Block accepts a byte in this cycle |
| mem_we | output | 1 | Packet RAM word write strobe |
| mem_addr | output | AW | Packet RAM word address |
| mem_wdata | output | 16 | Packet RAM write data |
| done | output | 1 | One-cycle pulse when the buffer is complete |

## Verification
The assertions assume that `in_valid` is never raised while `in_ready` is low. They also assume that every frame ends with a byte that carries `in_last`. Under these assumptions the tail of a frame always consists of three back-to-back writes, and the last of them, the count, is even and lands one word above the status word. The directed stimulus follows these assumptions. It presents bytes only in cycles where the block is ready, and it sets the last marker and the flags on the final byte of each frame. After that it waits for `done` before it starts the next frame.

// File: rtl/rx_pkt_writer.sv
module rx_pkt_writer #(
  parameter int AW       = 10,
  parameter int MAXD     = 1531,
  parameter logic [7:0] ODD_CTRL = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_addr,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          in_align,
  input  logic          in_bcast,
  input  logic          in_badcrc,
  input  logic          in_short,
  input  logic          in_mcast,
  input  logic [5:0]    in_hash,
  output logic          in_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  output logic          done
);
  localparam int CW = $clog2(MAXD + 6);
  localparam logic [CW-1:0] MAXC = CW'(MAXD);

  typedef enum logic [2:0] {S_RUN, S_TRL, S_STS, S_CNT, S_FIN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [7:0]    lo;
  logic [AW-1:0] base_q;
  logic          tl_q;
  logic [4:0]    fl_q;
  logic [5:0]    hash_q;

  wire take = in_valid && in_ready;
  wire keep = take && (cnt < MAXC);
  wire [AW-1:0] word_a = base_q + AW'(2) + AW'(cnt >> 1);

  assign in_ready = (st == S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RUN;
      cnt       <= '0;
      lo        <= '0;
      base_q    <= '0;
      tl_q      <= 1'b0;
      fl_q      <= '0;
      hash_q    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      done   <= 1'b0;
      case (st)
        S_RUN: if (take) begin
          if (cnt == '0) base_q <= base_addr;
          if (keep) begin
            cnt <= cnt + 1'b1;
            if (!cnt[0]) lo <= in_data;
            else begin
              mem_we    <= 1'b1;
              mem_addr  <= word_a;
              mem_wdata <= {in_data, lo};
            end
          end else begin
            tl_q <= 1'b1;
          end
          if (in_last) begin
            fl_q   <= {in_align, in_bcast, in_badcrc, in_short, in_mcast};
            hash_q <= in_hash;
            st     <= S_TRL;
          end
        end
        S_TRL: begin
          mem_we    <= 1'b1;
          mem_addr  <= word_a;
          mem_wdata <= cnt[0] ? {ODD_CTRL, lo} : 16'h0000;
          st        <= S_STS;
        end
        S_STS: begin
          mem_we    <= 1'b1;
          mem_addr  <= base_q;
          mem_wdata <= {fl_q[4:2], cnt[0], tl_q, fl_q[1], 3'b000, hash_q, fl_q[0]};
          st        <= S_CNT;
        end
        S_CNT: begin
          mem_we    <= 1'b1;
          mem_addr  <= base_q + AW'(1);
          mem_wdata <= 16'(cnt) + (cnt[0] ? 16'd5 : 16'd6);
          st        <= S_FIN;
        end
        default: begin
          done <= 1'b1;
          cnt  <= '0;
          tl_q <= 1'b0;
          st   <= S_RUN;
        end
      endcase
    end
  end
endmodule

// File: rtl/rx_pkt_writer_chk.sv
module rx_pkt_writer_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [15:0]   mem_wdata,
  input logic          done
);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  a_r7_no_write_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_we);

  a_r7_tail_burst: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mem_we, 1) && $past(mem_we, 2) && $past(mem_we, 3)));

  a_r5_count_even: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !$past(mem_wdata[0], 1));

  a_r5_count_above_status: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mem_addr, 1) == AW'($past(mem_addr, 2) + 1'b1)));
endmodule

bind rx_pkt_writer rx_pkt_writer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done)
);

// File: tb/sim_rx_pkt_writer.sv
module sim_rx_pkt_writer;
  localparam int AW = 10;
  localparam int MAXD = 1531;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = '0;
  logic          in_last = 1'b0;
  logic          in_align = 1'b0, in_bcast = 1'b0, in_badcrc = 1'b0;
  logic          in_short = 1'b0, in_mcast = 1'b0;
  logic [5:0]    in_hash = '0;
  logic          in_ready, mem_we, done;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata;

  logic [15:0] ram [1<<AW];
  int n_chk = 0;
  int n_bad = 0;

  rx_pkt_writer #(.AW(AW), .MAXD(MAXD)) u0 (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_align(in_align), .in_bcast(in_bcast),
    .in_badcrc(in_badcrc), .in_short(in_short), .in_mcast(in_mcast), .in_hash(in_hash),
    .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done(done)
  );

  always #10 clk = ~clk;

  always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((i * 13 + seed * 31 + 5) & 255);
  endfunction

  task automatic run_frame(input int base, input int len, input int seed,
                           input bit al, input bit bc, input bit crc,
                           input bit sh, input bit mc, input logic [5:0] hs,
                           input bit bump);
    int kept, nw, bad;
    logic [15:0] exp_st, exp_w;
    kept = (len > MAXD) ? MAXD : len;
    for (int a = 0; a < 772; a++) ram[(base + a) % (1 << AW)] = 16'hDEAD;
    base_addr = AW'(base);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_data  = pat(seed, i);
      in_last  = (i == len - 1);
      if (i == len - 1) begin
        in_align = al; in_bcast = bc; in_badcrc = crc; in_short = sh;
        in_mcast = mc; in_hash = hs;
      end else begin
        in_align = ~al; in_bcast = ~bc; in_badcrc = ~crc; in_short = ~sh;
        in_mcast = ~mc; in_hash = ~hs;
      end
      @(posedge clk); @(negedge clk);
      if (bump && i == 0) base_addr = AW'(base + 50);
    end
    in_valid = 1'b0; in_last = 1'b0;
    in_align = 1'b0; in_bcast = 1'b0; in_badcrc = 1'b0; in_short = 1'b0;
    in_mcast = 1'b0; in_hash = '0;
    chk(!in_ready && !done, "R7 ready low after last byte", {in_ready, done}, 0);
    for (int j = 1; j <= 3; j++) begin
      @(posedge clk); @(negedge clk);
      chk(!in_ready && !done, "R7 busy during tail writes", {in_ready, done}, 0);
    end
    @(posedge clk); @(negedge clk);
    chk(done && in_ready, "R7 done with ready", {in_ready, done}, 3);
    @(posedge clk); @(negedge clk);
    chk(!done, "R7 done one cycle", done, 0);

    exp_st = {al, bc, crc, kept[0], (len > MAXD), sh, 3'b000, hs, mc};
    chk(ram[base] == exp_st, "R3 R4 R10 status word", ram[base], exp_st);
    exp_w = 16'(kept + (kept[0] ? 5 : 6));
    chk(ram[base + 1] == exp_w, "R5 R8 byte count", ram[base + 1], exp_w);
    nw = kept / 2;
    bad = 0;
    for (int w = 0; w < nw; w++)
      if (ram[base + 2 + w] != {pat(seed, 2*w + 1), pat(seed, 2*w)}) bad++;
    chk(bad == 0, "R2 R9 data words", bad, 0);
    exp_w = kept[0] ? {8'h20, pat(seed, kept - 1)} : 16'h0000;
    chk(ram[base + 2 + nw] == exp_w, "R6 trailer word", ram[base + 2 + nw], exp_w);
    chk(ram[base + 3 + nw] == 16'hDEAD, "R8 R6 nothing past trailer",
        ram[base + 3 + nw], 16'hDEAD);
  endtask

  task automatic t_reset;
    #1;
    chk(in_ready && !done && !mem_we, "R1 state in reset", {in_ready, done, mem_we}, 4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(in_ready && !done && !mem_we, "R1 state after reset", {in_ready, done, mem_we}, 4);
  endtask

  task automatic t_even;      run_frame(0,   64, 1, 0, 1, 0, 0, 0, 6'h00, 0); endtask
  task automatic t_odd_flags; run_frame(100, 61, 2, 1, 0, 1, 1, 1, 6'h2B, 0); endtask
  task automatic t_single;    run_frame(200, 1,  3, 0, 0, 0, 0, 1, 6'h15, 0); endtask
  task automatic t_too_long;  run_frame(40, 1540, 4, 0, 0, 1, 0, 0, 6'h3F, 0); endtask
  task automatic t_base_move; run_frame(900, 20, 5, 0, 1, 0, 0, 0, 6'h01, 1); endtask
  task automatic t_max_even;  run_frame(10, 1530, 6, 0, 0, 0, 0, 1, 6'h20, 0); endtask

  initial begin
    t_reset();
    t_even();
    t_odd_flags();
    t_single();
    t_too_long();
    t_base_move();
    t_max_even();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule